// File: doc/BRIEF.md
# Level-1 Event Dispatcher with Worker Deadlines

This block takes a stream of level-1 event identifiers and hands each one to a pool of worker slots. A worker may hold only one event at a time. A dispatch takes the worker's token, and any return from that worker gives the token back. When an event is dispatched, the block starts a deadline counter for that slot. If the worker's decision arrives in time, the block forwards it with the event identifier. If the deadline runs out first, the block forwards a configurable fallback decision and marks it as timed out. A decision that arrives after the deadline produces no output, but it still returns the worker's token.

Every incoming event first enters a wait queue. The head of the queue leaves in one of two ways: it is dispatched to the lowest-numbered free slot, or it is dropped once it has waited too long. An event that waited in the queue gets a shorter deadline, reduced by the time it spent there. A throttle output with hysteresis reports when the queue is filling up, so that upstream logic can slow the event rate.

Top module: `event_dispatcher`

## Requirements
- R1: After a synchronous reset: no dispatch pulse, no decision output, throttle low, and `ev_ready` high.
- R2: Events leave the queue in arrival order. At most one event is dispatched per cycle, to the lowest-numbered free worker. The dispatch is a one-cycle one-hot pulse on `disp_valid` (bit k = worker k), with the identifier on `disp_id`. An event accepted at one clock edge can be dispatched at the next edge at the earliest.
- R3: A decision returned on `ret_*` by a worker whose deadline has not yet passed is emitted on `dec_*` with its event identifier and `dec_timeout` = 0.
- R4: Let T be the effective deadline of a dispatched event. If no decision is returned at any of the T clock edges after the dispatch edge, the slot expires at the T-th edge and the block emits `cfg_default_dec` with `dec_timeout` = 1. A return presented at that same edge wins over the expiry.
- R5: A return from a worker whose event has already expired produces no output, but it frees the worker for a later dispatch.
- R6: A worker is never sent a second event until its token has been returned and its pending output has been emitted.
- R7: The queue holds `QUEUE_DEPTH` (default 16) events. `ev_ready` is low exactly when the queue is full, and an event offered while `ev_ready` is low is lost.
- R8: At any edge where the queue is non-empty and the head's age (edges since acceptance) is at least `cfg_age_limit`, the head is dropped instead of dispatched. At most one event is dropped per cycle.
- R9: The effective deadline is T = `cfg_budget` − w, where w is the number of edges the event sat at or behind the queue head beyond the minimum one. T is clamped to at least 1.
- R10: At each edge, `throttle` goes high if the queue occupancy is at least `cfg_thr_high`. It goes low if the occupancy is below `cfg_thr_low`. Otherwise it holds.
- R11: At most one decision is emitted per cycle, one cycle after it becomes pending. When several are pending, the lowest-numbered worker goes first.
- R12: A return naming a worker that holds no token is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Incoming event present |
| ev_id | input | ID_W | Incoming event identifier |
| ev_ready | output | 1 | Queue can accept an event |
| disp_valid | output | NUM_WORKERS | One-hot dispatch pulse, bit per worker |
| disp_id | output | ID_W | Identifier of the dispatched event |
| ret_valid | input | 1 | Worker returns a decision and its token |
| ret_worker | input | $clog2(NUM_WORKERS) | Index of the returning worker |
| ret_dec | input | DEC_W | Returned decision value |
| dec_valid | output | 1 | Decision output strobe |
| dec_id | output | ID_W | Event identifier of the decision |
| dec_value | output | DEC_W | Decision value |
| dec_timeout | output | 1 | Decision is the fallback after expiry |
| throttle | output | 1 | Queue pressure indication |
| cfg_budget | input | TIME_W | Processing deadline in cycles |
| cfg_age_limit | input | TIME_W | Maximum queue age before dropping |
| cfg_default_dec | input | DEC_W | Fallback decision value |
| cfg_thr_high | input | $clog2(QUEUE_DEPTH+1) | Throttle set level |
| cfg_thr_low | input | $clog2(QUEUE_DEPTH+1) | Throttle release level |

## Verification
The hardest situation to reach from the ports is one where an expiry and a valid return land on the same edge for two different workers, so that two decisions are pending at once. The bench gets there by dispatching two events on consecutive edges with a short deadline and counting edges from the first dispatch. It then presents the second worker's return exactly at the first worker's expiry edge. A second hard case is a shortened deadline: all workers are kept busy while an event waits, and one worker is released only after a known delay. Queue drops and throttle release are reached by filling the queue behind workers that are never answered.

// File: rtl/ed_pkg.sv
// Package: shared definitions for the event dispatcher.
// Assumes: nothing beyond IEEE 1800-2017.
package ed_pkg;

    // Action taken on the queue head in a cycle
    typedef enum logic [1:0] {
        HEAD_HOLD     = 2'd0,
        HEAD_DROP     = 2'd1,
        HEAD_DISPATCH = 2'd2
    } head_act_e;

endpackage

// File: rtl/ed_pick_lowest.sv
// Module: one-hot selection of the lowest set bit of a request vector.
// Assumes: N >= 1; purely combinational.
module ed_pick_lowest #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [N-1:0] onehot
);

    // Scan from bit 0 upward and keep the first hit
    always_comb begin
        onehot = '0;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                onehot[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ed_wait_queue.sv
// Module: circular FIFO of event identifiers with the arrival timestamp of each entry.
// Assumes: the caller never pushes when full nor pops when empty; DEPTH >= 2.
module ed_wait_queue #(
    parameter int DEPTH  = 16,
    parameter int ID_W   = 8,
    parameter int TIME_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [TIME_W-1:0] push_stamp,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  count,
    output logic [ID_W-1:0]   head_id,
    output logic [TIME_W-1:0] head_stamp
);

    logic [ID_W-1:0]   id_mem    [DEPTH];
    logic [TIME_W-1:0] stamp_mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_q;

    assign empty      = (cnt_q == '0);
    assign full       = (cnt_q == CNT_W'(DEPTH));
    assign count      = cnt_q;
    assign head_id    = id_mem[rd_ptr];
    assign head_stamp = stamp_mem[rd_ptr];

    // Store the pushed entry
    always_ff @(posedge clk) begin
        if (push) begin
            id_mem[wr_ptr]    <= push_id;
            stamp_mem[wr_ptr] <= push_stamp;
        end
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R7
    // no_overflow_chk
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R7
    // no_underflow_chk
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

endmodule

// File: rtl/ed_worker_slot.sv
// Module: bookkeeping for one worker: token, running deadline and pending decision.
// Assumes: load is raised only when free is high; ret_hit is the decoded return strobe.
module ed_worker_slot #(
    parameter int ID_W   = 8,
    parameter int DEC_W  = 8,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ID_W-1:0]   load_id,
    input  logic [TIME_W-1:0] load_rem,
    input  logic              ret_hit,
    input  logic [DEC_W-1:0]  ret_dec,
    input  logic [DEC_W-1:0]  dflt_dec,
    input  logic              take,
    output logic              free,
    output logic              pend,
    output logic [ID_W-1:0]   pend_id,
    output logic [DEC_W-1:0]  pend_dec,
    output logic              pend_to
);

    logic              tok_q;
    logic              live_q;
    logic              pend_q;
    logic [TIME_W-1:0] rem_q;
    logic [ID_W-1:0]   id_q;
    logic [DEC_W-1:0]  dec_q;
    logic              to_q;

    assign free     = !tok_q && !pend_q;
    assign pend     = pend_q;
    assign pend_id  = id_q;
    assign pend_dec = dec_q;
    assign pend_to  = to_q;

    // Token, deadline countdown and decision capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q  <= 1'b0;
            live_q <= 1'b0;
            pend_q <= 1'b0;
            rem_q  <= '0;
            id_q   <= '0;
            dec_q  <= '0;
            to_q   <= 1'b0;
        end else begin
            if (load) begin
                tok_q  <= 1'b1;
                live_q <= 1'b1;
                rem_q  <= load_rem;
                id_q   <= load_id;
            end else begin
                if (ret_hit && tok_q) begin
                    tok_q <= 1'b0;
                end
                if (live_q) begin
                    if (ret_hit) begin
                        live_q <= 1'b0;
                        pend_q <= 1'b1;
                        dec_q  <= ret_dec;
                        to_q   <= 1'b0;
                    end else if (rem_q == '0) begin
                        live_q <= 1'b0;
                        pend_q <= 1'b1;
                        dec_q  <= dflt_dec;
                        to_q   <= 1'b1;
                    end else begin
                        rem_q <= rem_q - TIME_W'(1);
                    end
                end
            end
            if (take) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R6
    // load_when_free_chk
    load_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> free);

    // R4
    // expire_default_chk
    expire_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && rem_q == '0 && !ret_hit) |=> (pend_q && to_q && dec_q == $past(dflt_dec)));

    // R5
    // late_ret_silent_chk
    late_ret_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_q && !live_q && !pend_q && ret_hit) |=> (!pend_q && free));

endmodule

// File: rtl/ed_throttle.sv
// Module: hysteresis flag driven by queue occupancy.
// Assumes: the low mark is not above the high mark for a meaningful band.
module ed_throttle #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] mark_high,
    input  logic [CNT_W-1:0] mark_low,
    output logic             throttle
);

    logic thr_q;

    assign throttle = thr_q;

    // Set at the high mark, clear below the low mark, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= 1'b0;
        end else if (level >= mark_high) begin
            thr_q <= 1'b1;
        end else if (level < mark_low) begin
            thr_q <= 1'b0;
        end
    end

    // R10
    // thr_set_chk
    thr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= mark_high) |=> thr_q);

endmodule

// File: rtl/event_dispatcher.sv
// Module: queues level-1 events, dispatches them to token-holding worker slots,
// enforces per-slot deadlines and emits one decision per cycle.
// Assumes: NUM_WORKERS >= 2, QUEUE_DEPTH >= 2; queue ages stay below 2**TIME_W.
module event_dispatcher #(
    parameter int NUM_WORKERS = 8,
    parameter int QUEUE_DEPTH = 16,
    parameter int ID_W        = 8,
    parameter int DEC_W       = 8,
    parameter int TIME_W      = 16,
    localparam int WIDX_W     = $clog2(NUM_WORKERS),
    localparam int CNT_W      = $clog2(QUEUE_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ev_valid,
    input  logic [ID_W-1:0]        ev_id,
    output logic                   ev_ready,
    output logic [NUM_WORKERS-1:0] disp_valid,
    output logic [ID_W-1:0]        disp_id,
    input  logic                   ret_valid,
    input  logic [WIDX_W-1:0]      ret_worker,
    input  logic [DEC_W-1:0]       ret_dec,
    output logic                   dec_valid,
    output logic [ID_W-1:0]        dec_id,
    output logic [DEC_W-1:0]       dec_value,
    output logic                   dec_timeout,
    output logic                   throttle,
    input  logic [TIME_W-1:0]      cfg_budget,
    input  logic [TIME_W-1:0]      cfg_age_limit,
    input  logic [DEC_W-1:0]       cfg_default_dec,
    input  logic [CNT_W-1:0]       cfg_thr_high,
    input  logic [CNT_W-1:0]       cfg_thr_low
);
    import ed_pkg::*;

    logic [TIME_W-1:0]      now_q;
    logic                   q_empty, q_full, q_push, q_pop;
    logic [CNT_W-1:0]       q_count;
    logic [ID_W-1:0]        head_id;
    logic [TIME_W-1:0]      head_stamp, head_age, head_wait, load_rem;
    head_act_e              head_act;

    logic [NUM_WORKERS-1:0] slot_free, slot_pend, slot_load, slot_take, slot_hit, slot_pto;
    logic [NUM_WORKERS-1:0] free_1h, pend_1h;
    logic                   free_any, pend_any;
    logic [ID_W-1:0]        slot_pid  [NUM_WORKERS];
    logic [DEC_W-1:0]       slot_pdec [NUM_WORKERS];

    logic [ID_W-1:0]        sel_id;
    logic [DEC_W-1:0]       sel_dec;
    logic                   sel_to;

    logic [NUM_WORKERS-1:0] disp_q;
    logic [ID_W-1:0]        disp_id_q;
    logic                   dv_q, dto_q;
    logic [ID_W-1:0]        did_q;
    logic [DEC_W-1:0]       dval_q;

    // Free-running time base used to stamp queue entries
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + TIME_W'(1);
    end

    assign ev_ready = !q_full;
    assign q_push   = ev_valid && !q_full;

    ed_wait_queue #(
        .DEPTH (QUEUE_DEPTH),
        .ID_W  (ID_W),
        .TIME_W(TIME_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_id   (ev_id),
        .push_stamp(now_q),
        .pop       (q_pop),
        .empty     (q_empty),
        .full      (q_full),
        .count     (q_count),
        .head_id   (head_id),
        .head_stamp(head_stamp)
    );

    ed_pick_lowest #(.N(NUM_WORKERS)) u_pick_free (
        .req   (slot_free),
        .found (free_any),
        .onehot(free_1h)
    );

    ed_pick_lowest #(.N(NUM_WORKERS)) u_pick_pend (
        .req   (slot_pend),
        .found (pend_any),
        .onehot(pend_1h)
    );

    // Head age, queue wait beyond the minimum and the shortened deadline
    always_comb begin
        head_age  = now_q - head_stamp;
        head_wait = head_age - TIME_W'(1);
        load_rem  = (head_wait >= cfg_budget) ? '0 : cfg_budget - head_wait - TIME_W'(1);
    end

    // Decide whether the head is dropped, dispatched or held
    always_comb begin
        if (q_empty)                      head_act = HEAD_HOLD;
        else if (head_age >= cfg_age_limit) head_act = HEAD_DROP;
        else if (free_any)                head_act = HEAD_DISPATCH;
        else                              head_act = HEAD_HOLD;
    end

    assign q_pop = (head_act != HEAD_HOLD);

    // Per-worker slot instances with decoded load, return and take strobes
    for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_slot
        assign slot_load[w] = (head_act == HEAD_DISPATCH) && free_1h[w];
        assign slot_hit[w]  = ret_valid && (ret_worker == WIDX_W'(w));
        assign slot_take[w] = pend_1h[w];

        ed_worker_slot #(
            .ID_W  (ID_W),
            .DEC_W (DEC_W),
            .TIME_W(TIME_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (slot_load[w]),
            .load_id (head_id),
            .load_rem(load_rem),
            .ret_hit (slot_hit[w]),
            .ret_dec (ret_dec),
            .dflt_dec(cfg_default_dec),
            .take    (slot_take[w]),
            .free    (slot_free[w]),
            .pend    (slot_pend[w]),
            .pend_id (slot_pid[w]),
            .pend_dec(slot_pdec[w]),
            .pend_to (slot_pto[w])
        );
    end

    // Gather the fields of the selected pending slot
    always_comb begin
        sel_id  = '0;
        sel_dec = '0;
        sel_to  = 1'b0;
        for (int w = 0; w < NUM_WORKERS; w++) begin
            if (pend_1h[w]) begin
                sel_id  = slot_pid[w];
                sel_dec = slot_pdec[w];
                sel_to  = slot_pto[w];
            end
        end
    end

    // Register the dispatch pulse and the decision output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q    <= '0;
            disp_id_q <= '0;
            dv_q      <= 1'b0;
            did_q     <= '0;
            dval_q    <= '0;
            dto_q     <= 1'b0;
        end else begin
            disp_q <= slot_load;
            if (head_act == HEAD_DISPATCH) disp_id_q <= head_id;
            dv_q <= pend_any;
            if (pend_any) begin
                did_q  <= sel_id;
                dval_q <= sel_dec;
                dto_q  <= sel_to;
            end
        end
    end

    assign disp_valid  = disp_q;
    assign disp_id     = disp_id_q;
    assign dec_valid   = dv_q;
    assign dec_id      = did_q;
    assign dec_value   = dval_q;
    assign dec_timeout = dto_q;

    ed_throttle #(.CNT_W(CNT_W)) u_throttle (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (q_count),
        .mark_high(cfg_thr_high),
        .mark_low (cfg_thr_low),
        .throttle (throttle)
    );

    // R2
    // disp_onehot_chk
    disp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_valid));

    // R11
    // dec_follows_pend_chk
    dec_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any |=> dec_valid);

    // R8
    // drop_no_dispatch_chk
    drop_no_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_act == HEAD_DROP) |=> (disp_valid == '0));

endmodule

// File: tb/tb_event_dispatcher.sv
// Bench: behavioural reference model compared every clock, plus directed scenarios.
module tb_event_dispatcher;

    localparam int NW = 8;
    localparam int QD = 16;
    localparam int IW = 8;
    localparam int DW = 8;
    localparam int TW = 16;
    localparam int XW = $clog2(NW);
    localparam int CW = $clog2(QD + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic [IW-1:0] ev_id = '0;
    logic          ev_ready;
    logic [NW-1:0] disp_valid;
    logic [IW-1:0] disp_id;
    logic          ret_valid = 1'b0;
    logic [XW-1:0] ret_worker = '0;
    logic [DW-1:0] ret_dec = '0;
    logic          dec_valid;
    logic [IW-1:0] dec_id;
    logic [DW-1:0] dec_value;
    logic          dec_timeout;
    logic          throttle;
    logic [TW-1:0] cfg_budget = 16'd10;
    logic [TW-1:0] cfg_age_limit = 16'd100;
    logic [DW-1:0] cfg_default_dec = 8'hEE;
    logic [CW-1:0] cfg_thr_high = 5'd12;
    logic [CW-1:0] cfg_thr_low = 5'd4;

    event_dispatcher #(
        .NUM_WORKERS(NW), .QUEUE_DEPTH(QD), .ID_W(IW), .DEC_W(DW), .TIME_W(TW)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_id(ev_id), .ev_ready(ev_ready),
        .disp_valid(disp_valid), .disp_id(disp_id),
        .ret_valid(ret_valid), .ret_worker(ret_worker), .ret_dec(ret_dec),
        .dec_valid(dec_valid), .dec_id(dec_id), .dec_value(dec_value),
        .dec_timeout(dec_timeout), .throttle(throttle),
        .cfg_budget(cfg_budget), .cfg_age_limit(cfg_age_limit),
        .cfg_default_dec(cfg_default_dec), .cfg_thr_high(cfg_thr_high),
        .cfg_thr_low(cfg_thr_low)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int disp_count = 0;
    int dec_count = 0;
    int log_id[$];
    int log_val[$];
    int log_to[$];
    int log_cyc[$];

    // reference model state
    int m_tok[NW], m_live[NW], m_pend[NW], m_rem[NW], m_sid[NW], m_pdec[NW], m_pto[NW];
    int mq_id[$];
    int mq_st[$];
    int m_now, m_disp, m_disp_id, m_dv, m_did, m_dval, m_dto, m_thr;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        for (int w = 0; w < NW; w++) begin
            m_tok[w] = 0; m_live[w] = 0; m_pend[w] = 0; m_rem[w] = 0;
            m_sid[w] = 0; m_pdec[w] = 0; m_pto[w] = 0;
        end
        mq_id.delete();
        mq_st.delete();
        m_now = 0; m_disp = 0; m_disp_id = 0; m_dv = 0;
        m_did = 0; m_dval = 0; m_dto = 0; m_thr = 0;
    endtask

    task automatic model_step();
        int fsel, psel, cnt, age, waited;
        fsel = -1;
        for (int w = 0; w < NW; w++)
            if (fsel < 0 && !m_tok[w] && !m_pend[w]) fsel = w;
        cnt = mq_id.size();
        // output arbiter on pending decisions
        psel = -1;
        for (int w = 0; w < NW; w++)
            if (psel < 0 && m_pend[w]) psel = w;
        m_dv = (psel >= 0);
        if (psel >= 0) begin
            m_did = m_sid[psel]; m_dval = m_pdec[psel]; m_dto = m_pto[psel];
            m_pend[psel] = 0;
        end
        // worker returns and deadlines
        for (int w = 0; w < NW; w++) begin
            bit hit;
            hit = ret_valid && (int'(ret_worker) == w);
            if (hit && m_tok[w]) begin
                if (m_live[w]) begin
                    m_live[w] = 0; m_pend[w] = 1; m_pdec[w] = int'(ret_dec); m_pto[w] = 0;
                end
                m_tok[w] = 0;
            end else if (m_live[w]) begin
                if (m_rem[w] == 0) begin
                    m_live[w] = 0; m_pend[w] = 1; m_pdec[w] = int'(cfg_default_dec); m_pto[w] = 1;
                end else begin
                    m_rem[w]--;
                end
            end
        end
        // queue head
        m_disp = 0;
        if (cnt > 0) begin
            age = m_now - mq_st[0];
            if (age >= int'(cfg_age_limit)) begin
                void'(mq_id.pop_front()); void'(mq_st.pop_front());
            end else if (fsel >= 0) begin
                waited = age - 1;
                m_rem[fsel]  = (waited >= int'(cfg_budget)) ? 0 : int'(cfg_budget) - waited - 1;
                m_tok[fsel]  = 1; m_live[fsel] = 1; m_sid[fsel] = mq_id[0];
                m_disp = 1 << fsel; m_disp_id = mq_id[0];
                void'(mq_id.pop_front()); void'(mq_st.pop_front());
            end
        end
        if (ev_valid && cnt < QD) begin
            mq_id.push_back(int'(ev_id)); mq_st.push_back(m_now);
        end
        if (cnt >= int'(cfg_thr_high)) m_thr = 1;
        else if (cnt < int'(cfg_thr_low)) m_thr = 0;
        m_now++;
    endtask

    task automatic compare();
        chk(int'(disp_valid) == m_disp, "R2", "disp_valid", int'(disp_valid), m_disp);
        if (m_disp != 0) chk(int'(disp_id) == m_disp_id, "R2", "disp_id", int'(disp_id), m_disp_id);
        chk(dec_valid == m_dv[0], "R11", "dec_valid", int'(dec_valid), m_dv);
        if (m_dv != 0) begin
            chk(int'(dec_id) == m_did, "R3", "dec_id", int'(dec_id), m_did);
            chk(int'(dec_value) == m_dval, "R3", "dec_value", int'(dec_value), m_dval);
            chk(int'(dec_timeout) == m_dto, "R4", "dec_timeout", int'(dec_timeout), m_dto);
        end
        chk(throttle == m_thr[0], "R10", "throttle", int'(throttle), m_thr);
        chk(ev_ready == (mq_id.size() != QD), "R7", "ev_ready", int'(ev_ready), int'(mq_id.size() != QD));
        if (disp_valid != '0) disp_count++;
        if (dec_valid) begin
            dec_count++;
            log_id.push_back(int'(dec_id)); log_val.push_back(int'(dec_value));
            log_to.push_back(int'(dec_timeout)); log_cyc.push_back(cyc);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        if (!rst_n) model_reset();
        else        model_step();
        cyc++;
        @(negedge clk);
        if (rst_n) compare();
    endtask

    task automatic push_ev(input int id);
        ev_valid = 1'b1; ev_id = IW'(id);
        cycle();
        ev_valid = 1'b0;
    endtask

    task automatic give_ret(input int w, input int d);
        ret_valid = 1'b1; ret_worker = XW'(w); ret_dec = DW'(d);
        cycle();
        ret_valid = 1'b0;
    endtask

    task automatic wait_disp(output int w);
        w = -1;
        for (int i = 0; i < 60 && w < 0; i++) begin
            cycle();
            for (int k = 0; k < NW; k++) if (disp_valid[k] && w < 0) w = k;
        end
    endtask

    task automatic wait_dec_of(input int id, output int at);
        at = -1;
        for (int i = 0; i < 80 && at < 0; i++) begin
            cycle();
            if (dec_valid && int'(dec_id) == id) at = cyc;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic release_all();
        for (int w = 0; w < NW; w++) give_ret(w, 8'h01);
        idle(20);
    endtask

    // watchdog: a hung run is counted as a failure
    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int w, at, n0, d0, t0, seen;
        model_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        cycle();
        // R1 reset state
        chk(disp_valid == '0, "R1", "disp after reset", int'(disp_valid), 0);
        chk(!dec_valid, "R1", "dec after reset", int'(dec_valid), 0);
        chk(!throttle, "R1", "throttle after reset", int'(throttle), 0);
        chk(ev_ready, "R1", "ev_ready after reset", int'(ev_ready), 1);

        // R3: timely decision forwarded
        push_ev(8'h11);
        wait_disp(w);
        chk(w == 0, "R2", "lowest free worker", w, 0);
        idle(2);
        give_ret(0, 8'h5A);
        wait_dec_of(8'h11, at);
        chk(at > 0 && log_val[$] == 8'h5A, "R3", "forwarded value", log_val[$], 8'h5A);
        chk(log_to[$] == 0, "R3", "forwarded timeout flag", log_to[$], 0);

        // R4, R5, R6: expiry, late return, token reuse
        push_ev(8'h22);
        wait_disp(w);
        chk(w == 0, "R2", "reuse worker 0", w, 0);
        wait_dec_of(8'h22, at);
        chk(log_to[$] == 1 && log_val[$] == 8'hEE, "R4", "default decision", log_val[$], 8'hEE);
        push_ev(8'h23);
        wait_disp(w);
        chk(w == 1, "R6", "busy worker 0 skipped", w, 1);
        n0 = dec_count;
        give_ret(0, 8'h33);
        idle(3);
        chk(dec_count == n0, "R5", "late return silent", dec_count, n0);
        push_ev(8'h24);
        wait_disp(w);
        chk(w == 0, "R5", "late return frees token", w, 0);
        release_all();

        // R12: return from a worker without token
        n0 = dec_count;
        give_ret(5, 8'h77);
        idle(3);
        chk(dec_count == n0, "R12", "tokenless return ignored", dec_count, n0);

        // R7, R8, R10: fill the queue behind busy workers, then drain by age
        cfg_budget = 16'd1000; cfg_age_limit = 16'd40;
        for (int i = 0; i < NW + QD; i++) push_ev(8'h60 + i);
        chk(!ev_ready, "R7", "ev_ready low when full", int'(ev_ready), 0);
        chk(throttle, "R10", "throttle high at watermark", int'(throttle), 1);
        t0 = disp_count;
        push_ev(8'hFF);
        idle(60);
        chk(!throttle, "R10", "throttle released", int'(throttle), 0);
        chk(ev_ready, "R8", "queue drained by age", int'(ev_ready), 1);
        chk(disp_count == t0, "R8", "aged events not dispatched", disp_count, t0);
        release_all();
        chk(disp_count == t0, "R8", "no stale dispatch after release", disp_count, t0);

        // R9: deadline shortened by queue wait
        cfg_budget = 16'd20; cfg_age_limit = 16'd100;
        for (int i = 0; i < NW; i++) push_ev(8'h40 + i);
        push_ev(8'h99);
        idle(12);
        give_ret(3, 8'h12);
        wait_disp(w);
        chk(w == 3, "R9", "waiting event takes freed worker", w, 3);
        d0 = cyc;
        wait_dec_of(8'h99, at);
        chk(at > d0 && (at - d0) < 20, "R9", "shortened deadline", at - d0, 19);
        chk(log_to[$] == 1, "R9", "waited event expired", log_to[$], 1);
        release_all();

        // R11: expiry and return on the same edge, lowest worker first
        cfg_budget = 16'd5;
        ev_valid = 1'b1; ev_id = 8'hA1;
        cycle();
        ev_id = 8'hB2;
        cycle();
        ev_valid = 1'b0;
        chk(disp_valid == 8'h01, "R2", "first of pair to worker 0", int'(disp_valid), 1);
        idle(4);
        n0 = log_id.size();
        give_ret(1, 8'h3C);
        idle(3);
        seen = log_id.size() - n0;
        chk(seen == 2, "R11", "two decisions", seen, 2);
        if (seen == 2) begin
            chk(log_id[n0] == 8'hA1 && log_to[n0] == 1, "R11", "worker 0 first", log_id[n0], 8'hA1);
            chk(log_id[n0+1] == 8'hB2 && log_to[n0+1] == 0, "R11", "worker 1 second", log_id[n0+1], 8'hB2);
            chk(log_cyc[n0+1] == log_cyc[n0] + 1, "R11", "back to back", log_cyc[n0+1] - log_cyc[n0], 1);
        end
        release_all();

        // mixed random traffic against the model
        cfg_budget = 16'd15; cfg_age_limit = 16'd30;
        cfg_thr_high = 5'd10; cfg_thr_low = 5'd3;
        for (int i = 0; i < 4000; i++) begin
            ev_valid   = ($urandom_range(0, 9) < 4);
            ev_id      = IW'($urandom_range(0, 255));
            ret_valid  = ($urandom_range(0, 9) < 3);
            ret_worker = XW'($urandom_range(0, NW - 1));
            ret_dec    = DW'($urandom_range(0, 255));
            cycle();
        end
        ev_valid = 1'b0; ret_valid = 1'b0;
        idle(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule